// File: doc/BRIEF.md
# Auto Baud Rate Detector

This block watches an idle-high serial receive line and times the first character that arrives after it is armed. From that timing it produces a baud divisor, expressed as kernel-clock cycles per bit period. A receiver that follows it can load the divisor directly. Decoding the character's data and driving a receiver with the result are left to other logic.

A two-bit mode input, sampled on the arm strobe, picks one of four ways to measure. The first mode times only the start bit. The second times the start bit together with the first data bit and halves the result. The third expects a character of seven ones followed by a zero. It takes a first estimate from the start bit and a final one from the start edge to the falling edge that ends data bit 6. The fourth expects an alternating character. It refines its estimate three times and checks every intermediate transition against the current estimate. Each arm gives exactly one measurement. The block then reports either a one-cycle done pulse or a held error flag, and waits for the next arm.

Top module: `abr_detect`

## Requirements
- R1: After reset, `divisor` is 0, `done` is 0 and `err` is 0.
- R2: Mode 2'b00: the divisor is the number of cycles from the start-bit falling edge to the next rising edge, and the result is final at that edge.
- R3: Mode 2'b01: the first rising edge is skipped. The divisor is the count from the start-bit falling edge to the next falling edge, shifted right by one (truncated), and the result is final at that edge.
- R4: Mode 2'b10: at the first rising edge the divisor is set to the start-bit length. At the next falling edge it is set to the elapsed count since the start edge, shifted right by three, and the result is final.
- R5: Mode 2'b11: the divisor is set at the 1st edge after the start edge (elapsed count), at the 2nd edge (elapsed shifted right by one) and at the 8th edge (elapsed shifted right by three). The 8th-edge update is final.
- R6: Mode 2'b11: at edges 3 to 7 the elapsed count is compared with edge-index times divisor. A deviation up to and including divisor>>2 is accepted. A larger deviation raises `err`, ends the run, and leaves the divisor at its last updated value.
- R7: Any update value below MIN_DIV (16) raises `err`, ends the run, and leaves the divisor unchanged.
- R8: If no edge arrives before the elapsed count reaches 2^CNT_W-1, `err` is raised and the run ends. An edge that arrives exactly at that count is still measured.
- R9: `done` is high for exactly one cycle when the final update is made. Line activity while the block is not armed changes neither `divisor` nor `done`.
- R10: `arm` clears `err`, samples `mode`, and starts a new run. Changes on `mode` after that do not affect the run.
- R11: `err` stays set until the next `arm`, and `done` is never high while `err` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial receive line, idle high, asynchronous |
| mode | input | 2 | Measurement method, sampled on `arm` |
| arm | input | 1 | Strobe that starts one measurement |
| divisor | output | CNT_W | Measured cycles per bit |
| done | output | 1 | One-cycle pulse on the final update |
| err | output | 1 | Measurement failed; held until the next arm |

## Verification
The overflow guard and an edge can fall in the same cycle. This happens when a bit period equals 2^CNT_W-1 cycles, so the counter reaches its ceiling in the very cycle the edge is detected. The bench provokes it by holding the start bit low for exactly that many cycles, and expects a clean result equal to the ceiling with no error. One cycle longer must give an error and a frozen divisor. In the alternating mode, a transition placed exactly one quarter bit late must be accepted, and one cycle later than that must be rejected.

// File: rtl/abr_detect.sv
module abr_detect #(
  parameter int CNT_W       = 16,
  parameter int MIN_DIV     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic [1:0]       mode,
  input  logic             arm,
  output logic [CNT_W-1:0] divisor,
  output logic             done,
  output logic             err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(MIN_DIV);
  localparam int               XW      = CNT_W + 4;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_MEAS} st_t;

  st_t                    state;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_q;
  logic [1:0]             mode_q;
  logic [CNT_W-1:0]       cnt;
  logic [3:0]             idx;

  wire       rx_s   = sync_q[SYNC_STAGES-1];
  wire       edge_s = rx_s ^ rx_q;
  wire       fall_s = rx_q & ~rx_s;
  wire [3:0] idx_n  = idx + 4'd1;

  logic [XW-1:0] expv, cntx, dev, tol;
  assign expv = {{CNT_W{1'b0}}, idx_n} * {4'b0, divisor};
  assign cntx = {4'b0, cnt};
  assign dev  = (cntx >= expv) ? cntx - expv : expv - cntx;
  assign tol  = {6'b0, divisor[CNT_W-1:2]};

  logic             upd, fin, miss;
  logic [CNT_W-1:0] val;

  always_comb begin
    upd  = 1'b0;
    fin  = 1'b0;
    miss = 1'b0;
    val  = cnt;
    if (state == S_MEAS && edge_s) begin
      case (mode_q)
        2'd0: begin
          upd = 1'b1;
          fin = 1'b1;
        end
        2'd1: if (fall_s) begin
          upd = 1'b1;
          fin = 1'b1;
          val = cnt >> 1;
        end
        2'd2: begin
          upd = 1'b1;
          if (idx_n != 4'd1) begin
            fin = 1'b1;
            val = cnt >> 3;
          end
        end
        default: case (idx_n)
          4'd1: upd = 1'b1;
          4'd2: begin
            upd = 1'b1;
            val = cnt >> 1;
          end
          4'd8: begin
            upd = 1'b1;
            fin = 1'b1;
            val = cnt >> 3;
          end
          default: miss = (dev > tol);
        endcase
      endcase
    end
  end

  wire too_low = upd && (val < MIN_V);
  wire ovf     = (state == S_MEAS) && !edge_s && (cnt == CNT_MAX);
  wire fault   = too_low | miss | ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      rx_q   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx};
      rx_q   <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mode_q  <= 2'd0;
      cnt     <= '0;
      idx     <= '0;
      divisor <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        state  <= S_ARMED;
        mode_q <= mode;
        err    <= 1'b0;
      end else begin
        case (state)
          S_ARMED: if (fall_s) begin
            state <= S_MEAS;
            cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
            idx   <= '0;
          end
          S_MEAS: begin
            cnt <= cnt + 1'b1;
            if (edge_s) idx <= idx_n;
            if (fault) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              if (upd) divisor <= val;
              if (fin) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module abr_detect_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic [CNT_W-1:0] divisor,
  input logic             done,
  input logic             err
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) done |-> !err); // R11
  AST_DONE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) done |-> (divisor >= CNT_W'(MIN_DIV))); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (err && !arm) |=> err); // R11
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (err && !arm) |=> $stable(divisor)); // R7
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) arm |=> (!err && !done)); // R10

endmodule

bind abr_detect abr_detect_chk #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_chk (.*);

// File: tb/abr_detect_bench.sv
module abr_detect_bench;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic          arm = 1'b0;
  logic [CW-1:0] divisor;
  logic          done;
  logic          err;

  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;
  int cyc = 0;

  abr_detect #(.CNT_W(CW), .MIN_DIV(16), .SYNC_STAGES(2)) u_abr_detect (
    .clk(clk), .rst_n(rst_n), .rx(rx), .mode(mode), .arm(arm),
    .divisor(divisor), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (done) n_done++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lvl(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int p);
    lvl(1'b0, p);
    for (int i = 0; i < 8; i++) lvl(b[i], p);
    lvl(1'b1, 2 * p);
  endtask

  task automatic do_arm(input logic [1:0] m);
    rx = 1'b1;
    mode = m;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 divisor", int'(divisor), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
  endtask

  task automatic t_mode0;
    int d0;
    d0 = n_done;
    do_arm(2'd0);
    send_frame(8'h35, 37);
    check("R2 divisor p37", int'(divisor), 37);
    check("R2 done count", n_done - d0, 1);
    do_arm(2'd0);
    send_frame(8'hFF, 100);
    check("R2 divisor p100", int'(divisor), 100);
    check("R2 err", int'(err), 0);
  endtask

  task automatic t_mode1;
    int d0;
    d0 = n_done;
    do_arm(2'd1);
    send_frame(8'h01, 50);
    check("R3 divisor even", int'(divisor), 50);
    do_arm(2'd1);
    lvl(1'b0, 50); lvl(1'b1, 51);
    for (int i = 1; i < 8; i++) lvl(1'b0, 50);
    lvl(1'b1, 100);
    check("R3 divisor odd span truncated", int'(divisor), 50);
    check("R3 done count", n_done - d0, 2);
  endtask

  task automatic t_mode2;
    int d0;
    d0 = n_done;
    do_arm(2'd2);
    lvl(1'b0, 30);
    lvl(1'b1, 3 * 24);
    check("R4 interim start-bit divisor", int'(divisor), 30);
    check("R4 no done yet", n_done - d0, 0);
    lvl(1'b1, 4 * 24);
    lvl(1'b0, 24);
    lvl(1'b1, 48);
    check("R4 final divisor", int'(divisor), 24);
    check("R4 done count", n_done - d0, 1);
  endtask

  task automatic rest55;
    lvl(1'b0, 40); lvl(1'b1, 40); lvl(1'b0, 40); lvl(1'b1, 40); lvl(1'b0, 40);
    lvl(1'b1, 80);
  endtask

  task automatic t_mode3;
    int d0;
    d0 = n_done;
    do_arm(2'd3);
    send_frame(8'h55, 40);
    check("R5 divisor clean", int'(divisor), 40);
    check("R5 done count", n_done - d0, 1);
    do_arm(2'd3);
    lvl(1'b0, 40); lvl(1'b1, 40); lvl(1'b0, 45); lvl(1'b1, 35);
    rest55();
    check("R6 small jitter divisor", int'(divisor), 40);
    check("R6 small jitter err", int'(err), 0);
    do_arm(2'd3);
    lvl(1'b0, 40); lvl(1'b1, 40); lvl(1'b0, 50); lvl(1'b1, 30);
    rest55();
    check("R6 quarter-bit boundary err", int'(err), 0);
    check("R6 boundary done count", n_done - d0, 3);
  endtask

  task automatic t_mode3_bad;
    int d0;
    d0 = n_done;
    do_arm(2'd3);
    lvl(1'b0, 44); lvl(1'b1, 40); lvl(1'b0, 53);
    lvl(1'b1, 40);
    rest55();
    check("R6 late edge err", int'(err), 1);
    check("R5 R6 divisor held at 2nd-edge value", int'(divisor), 42);
    check("R11 no done with err", n_done - d0, 0);
    repeat (20) @(negedge clk);
    check("R11 err held", int'(err), 1);
  endtask

  task automatic t_low;
    do_arm(2'd0);
    check("R10 err cleared by arm", int'(err), 0);
    send_frame(8'hFF, 15);
    check("R7 short bit err", int'(err), 1);
    check("R7 divisor unchanged", int'(divisor), 42);
    do_arm(2'd0);
    send_frame(8'hFF, 16);
    check("R7 floor accepted", int'(divisor), 16);
    check("R7 floor err", int'(err), 0);
  endtask

  task automatic t_ovf;
    do_arm(2'd0);
    lvl(1'b0, 4096);
    lvl(1'b1, 20);
    check("R8 overflow err", int'(err), 1);
    check("R8 divisor unchanged", int'(divisor), 16);
    do_arm(2'd0);
    lvl(1'b0, 4095);
    lvl(1'b1, 20);
    check("R8 edge at ceiling err", int'(err), 0);
    check("R8 edge at ceiling divisor", int'(divisor), 4095);
  endtask

  task automatic t_ignore;
    int d0;
    d0 = n_done;
    send_frame(8'h55, 60);
    send_frame(8'h35, 20);
    check("R9 idle divisor unchanged", int'(divisor), 4095);
    check("R9 idle done count", n_done - d0, 0);
  endtask

  task automatic t_latch;
    int d0;
    d0 = n_done;
    do_arm(2'd0);
    mode = 2'd3;
    lvl(1'b0, 32);
    lvl(1'b1, 10);
    check("R10 mode sampled at arm done", n_done - d0, 1);
    check("R10 mode sampled at arm divisor", int'(divisor), 32);
    lvl(1'b1, 22);
    lvl(1'b0, 32); lvl(1'b1, 32); lvl(1'b0, 32);
    lvl(1'b1, 64);
    check("R9 single done per arm", n_done - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode3_bad();
    t_low();
    t_ovf();
    t_ignore();
    t_latch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule